// File: doc/BRIEF.md
# Shared-Bus Load and Result Sequencer

A group of identical processing units sits in a reconfigurable fabric and shares one data bus to main memory. The units are brought up one after another on a separate configuration channel. Each of them takes the same configuration time. The sequencer owns the data bus. It starts each unit's configuration in turn. It grants the bus for a unit's input burst as soon as that unit is configured. It times the unit's computation, and then grants the bus again so the unit can return its result. The result burst has the same length as the input burst.

Before a run, software programs three things: a burst length and a compute latency for each unit, and one shared configuration time. A start pulse then runs the whole schedule. Results return strictly in unit order, and a result that is ready wins the bus over a pending input burst. Because of this, results fill the gaps that slow configuration leaves between input bursts, and the result stream packs together. A one-cycle done pulse closes the run, and an elapsed-cycle count reports the schedule length.

Cycle numbering used below: the clock edge that samples `start_i` is edge 0, and "at edge e" means the registered outputs change at that edge.

Top module: `shared_bus_sequencer`

## Requirements
- R1: A write with `wr_en_i` stores `wr_data_i` as follows. Field code 0 is the burst length of unit `wr_unit_i`. Field code 1 is that unit's compute latency. Field code 2 is the shared configuration time T, and the unit index is not used. A result burst uses the same length as the same unit's input burst.
- R2: The configure-start pulse of unit k is one cycle wide and appears at edge k*T, one unit at a time in index order. A programmed T of 0 behaves as T = 1.
- R3: The input burst of unit k is never granted before edge (k+1)*T+1. Input bursts are granted in ascending unit order.
- R4: A grant stays unchanged until `burst_done_i` is sampled high. `gnt_vec_o` is the one-hot form of `gnt_idx_o`. `gnt_dir_o` is 0 for an input burst and 1 for a result burst. `gnt_len_o` carries the unit's programmed burst length.
- R5: If a unit's input burst ends at edge R (the edge that samples `burst_done_i`), its result becomes eligible at edge R+L+1, where L is its compute latency.
- R6: Result bursts are granted in ascending unit order. This holds even when a later unit finished computing earlier.
- R7: If the next result and the next input burst are both eligible at the same edge, the result is granted.
- R8: A new grant can take effect at the same edge that ends the previous burst, so no idle cycle is inserted between bursts.
- R9: `done_o` is high for exactly one cycle, starting at the edge that ends the last unit's result burst. `elapsed_o` then holds that edge's number.
- R10: A start pulse that arrives while a schedule is running has no effect on that schedule.
- R11: After reset, there is no grant, no configure pulse, no done pulse, and `elapsed_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Parameter write strobe |
| wr_unit_i | input | IDX_W | Unit addressed by the write |
| wr_sel_i | input | 2 | Field code: 0 length, 1 latency, 2 configuration time |
| wr_data_i | input | DATA_W | Value written |
| start_i | input | 1 | Starts a schedule when idle |
| burst_done_i | input | 1 | Current burst has completed |
| cfg_start_o | output | N_UNITS | One-hot configure-start pulse |
| gnt_valid_o | output | 1 | Bus is granted |
| gnt_vec_o | output | N_UNITS | One-hot granted unit |
| gnt_idx_o | output | IDX_W | Granted unit index |
| gnt_dir_o | output | 1 | 0 input burst, 1 result burst |
| gnt_len_o | output | DATA_W | Length of granted burst |
| done_o | output | 1 | One-cycle end-of-schedule pulse |
| elapsed_o | output | CNT_W | Cycles from start to last result release |

## Verification
The bench compares every grant's unit, direction and starting edge against hand-derived schedules. The cases cover a configuration time short enough that input bursts pack together, a long configuration time where each result slips into the following gap, mixed lengths and latencies where a later unit finishes first, and a zero configuration time. A design that let results overtake one another, or let a pending input burst beat a ready result, would shift a grant start or change the order. A design that inserted a turnaround cycle would push every later start back by one. A stray start in mid-run, a done pulse wider than one cycle, and an off-by-one elapsed count each show up as a mismatch at the ports.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    FLD_LENGTH  = 2'd0,
    FLD_LATENCY = 2'd1,
    FLD_RECONF  = 2'd2
  } field_e;

  typedef enum logic {
    DIR_LOAD   = 1'b0,
    DIR_RESULT = 1'b1
  } dir_e;
endpackage

// File: rtl/sls_param_store.sv
module sls_param_store
  import sls_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_unit_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  len_idx_i,
  output logic [DATA_W-1:0] len_o,
  input  logic [IDX_W-1:0]  lat_idx_i,
  output logic [DATA_W-1:0] lat_o,
  output logic [DATA_W-1:0] reconf_o
);
  logic [DATA_W-1:0] len_mem [N_UNITS];
  logic [DATA_W-1:0] lat_mem [N_UNITS];
  logic [DATA_W-1:0] reconf_q;
  logic              unit_ok;

  assign unit_ok = (32'(wr_unit_i) < N_UNITS);

  // Small per-unit arrays: written by one port, read asynchronously.
  always_ff @(posedge clk) begin
    if (wr_en_i && unit_ok && field_e'(wr_sel_i) == FLD_LENGTH)
      len_mem[wr_unit_i] <= wr_data_i;
    if (wr_en_i && unit_ok && field_e'(wr_sel_i) == FLD_LATENCY)
      lat_mem[wr_unit_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reconf_q <= '0;
    else if (wr_en_i && field_e'(wr_sel_i) == FLD_RECONF)
      reconf_q <= wr_data_i;
  end

  assign len_o    = len_mem[len_idx_i];
  assign lat_o    = lat_mem[lat_idx_i];
  assign reconf_o = reconf_q;
endmodule

// File: rtl/sls_cfg_chain.sv
module sls_cfg_chain #(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [DATA_W-1:0]  tr_i,
  output logic [N_UNITS-1:0] cfg_start_o,
  output logic [N_UNITS-1:0] cfg_done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_UNITS - 1);
  localparam logic [N_UNITS-1:0] ONE_HOT0 = {{(N_UNITS-1){1'b0}}, 1'b1};

  logic              active_q;
  logic [IDX_W-1:0]  cur_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] tr_eff;
  logic [N_UNITS-1:0] start_q, done_q;

  assign tr_eff = (tr_i == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : tr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cur_q    <= '0;
      cnt_q    <= '0;
      start_q  <= '0;
      done_q   <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      cur_q    <= '0;
      cnt_q    <= tr_eff;
      start_q  <= ONE_HOT0;
      done_q   <= '0;
    end else begin
      start_q <= '0;
      if (active_q) begin
        if (cnt_q == {{(DATA_W-1){1'b0}}, 1'b1}) begin
          done_q[cur_q] <= 1'b1;
          if (cur_q == LAST_IDX) begin
            active_q <= 1'b0;
          end else begin
            cur_q   <= cur_q + 1'b1;
            cnt_q   <= tr_eff;
            start_q <= ONE_HOT0 << (cur_q + 1'b1);
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cfg_start_o = start_q;
  assign cfg_done_o  = done_q;

  AST_CFG_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_q)); // R2

  AST_CFG_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_q[0] && !go_i) |=> done_q[0]); // R3
endmodule

// File: rtl/sls_compute_timers.sv
module sls_compute_timers #(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_i,
  input  logic               launch_i,
  input  logic [IDX_W-1:0]   launch_idx_i,
  input  logic [DATA_W-1:0]  lat_i,
  output logic [N_UNITS-1:0] comp_done_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
    logic [DATA_W-1:0] cnt_q;
    logic              fin_q;
    logic              hit;

    assign hit = launch_i && (launch_idx_i == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        cnt_q <= '0;
        fin_q <= 1'b0;
      end else if (hit) begin
        if (lat_i == '0) fin_q <= 1'b1;
        else             cnt_q <= lat_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == ONE) fin_q <= 1'b1;
      end
    end

    assign comp_done_o[k] = fin_q;

    AST_COMPUTE_NO_EARLY_FINISH: assert property (@(posedge clk) disable iff (rst)
      (cnt_q > ONE && !clear_i) |=> !fin_q); // R5
  end
endmodule

// File: rtl/sls_bus_arbiter.sv
module sls_bus_arbiter
  import sls_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  localparam int PTR_W  = $clog2(N_UNITS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_i,
  input  logic               run_i,
  input  logic [N_UNITS-1:0] cfg_done_i,
  input  logic [N_UNITS-1:0] comp_done_i,
  input  logic               burst_done_i,
  input  logic [DATA_W-1:0]  nxt_len_i,
  output logic [IDX_W-1:0]   nxt_idx_o,
  output logic               gnt_valid_o,
  output logic               gnt_dir_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic [N_UNITS-1:0] gnt_vec_o,
  output logic [DATA_W-1:0]  gnt_len_o,
  output logic               load_rel_o,
  output logic               last_rel_o
);
  localparam logic [PTR_W-1:0]   PTR_END  = PTR_W'(N_UNITS);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(N_UNITS - 1);
  localparam logic [N_UNITS-1:0] ONE_HOT0 = {{(N_UNITS-1){1'b0}}, 1'b1};

  logic               busy_q;
  dir_e               dir_q;
  logic [IDX_W-1:0]   idx_q;
  logic [N_UNITS-1:0] vec_q;
  logic [DATA_W-1:0]  len_q;
  logic [PTR_W-1:0]   lptr_q, rptr_q;

  logic               ending, res_end, ld_end, bus_free;
  logic [PTR_W-1:0]   r_cand, l_cand;
  logic [IDX_W-1:0]   r_sel, l_sel;
  logic               r_ok, l_ok;

  always_comb begin
    ending   = busy_q && burst_done_i;
    res_end  = ending && (dir_q == DIR_RESULT);
    ld_end   = ending && (dir_q == DIR_LOAD);
    bus_free = !busy_q || burst_done_i;
    r_cand   = rptr_q + PTR_W'(res_end);
    l_cand   = lptr_q + PTR_W'(ld_end);
    r_sel    = r_cand[IDX_W-1:0];
    l_sel    = l_cand[IDX_W-1:0];
    // A ready result of the next unit in order beats any input burst.
    r_ok     = run_i && bus_free && (r_cand < PTR_END) && comp_done_i[r_sel];
    l_ok     = run_i && bus_free && !r_ok && (l_cand < PTR_END) && cfg_done_i[l_sel];
    nxt_idx_o = r_ok ? r_sel : l_sel;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_LOAD;
      idx_q  <= '0;
      vec_q  <= '0;
      len_q  <= '0;
      lptr_q <= '0;
      rptr_q <= '0;
    end else begin
      rptr_q <= r_cand;
      lptr_q <= l_cand;
      if (ending) begin
        busy_q <= 1'b0;
        vec_q  <= '0;
      end
      if (r_ok || l_ok) begin
        busy_q <= 1'b1;
        dir_q  <= r_ok ? DIR_RESULT : DIR_LOAD;
        idx_q  <= nxt_idx_o;
        vec_q  <= ONE_HOT0 << nxt_idx_o;
        len_q  <= nxt_len_i;
      end
    end
  end

  assign gnt_valid_o = busy_q;
  assign gnt_dir_o   = dir_q;
  assign gnt_idx_o   = idx_q;
  assign gnt_vec_o   = vec_q;
  assign gnt_len_o   = len_q;
  assign load_rel_o  = ld_end;
  assign last_rel_o  = res_end && (idx_q == LAST_IDX);

  AST_GNT_VEC_MATCHES: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> $onehot(vec_q) && vec_q[idx_q]); // R4

  AST_GNT_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !burst_done_i && !clear_i) |=> busy_q && $stable(idx_q) && $stable(dir_q)); // R4

  AST_LOAD_AFTER_CFG: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dir_q == DIR_LOAD) |-> cfg_done_i[idx_q]); // R3

  AST_RESULT_AFTER_COMPUTE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dir_q == DIR_RESULT) |-> comp_done_i[idx_q]); // R5

  AST_RESULT_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dir_q == DIR_RESULT) |-> (lptr_q > PTR_W'(idx_q))); // R6
endmodule

// File: rtl/shared_bus_sequencer.sv
module shared_bus_sequencer
  import sls_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_unit_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               start_i,
  input  logic               burst_done_i,
  output logic [N_UNITS-1:0] cfg_start_o,
  output logic               gnt_valid_o,
  output logic [N_UNITS-1:0] gnt_vec_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic               gnt_dir_o,
  output logic [DATA_W-1:0]  gnt_len_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   elapsed_o
);
  logic               run_q, done_q, go;
  logic [CNT_W-1:0]   elapsed_q;
  logic [DATA_W-1:0]  rd_len, rd_lat, reconf;
  logic [IDX_W-1:0]   nxt_idx;
  logic [N_UNITS-1:0] cfg_done, comp_done;
  logic               load_rel, last_rel;

  assign go = start_i && !run_q;

  sls_param_store #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) store_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_unit_i (wr_unit_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .len_idx_i (nxt_idx),
    .len_o     (rd_len),
    .lat_idx_i (gnt_idx_o),
    .lat_o     (rd_lat),
    .reconf_o  (reconf)
  );

  sls_cfg_chain #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) cfg_i (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go),
    .tr_i        (reconf),
    .cfg_start_o (cfg_start_o),
    .cfg_done_o  (cfg_done)
  );

  sls_compute_timers #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) comp_i (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (go),
    .launch_i     (load_rel),
    .launch_idx_i (gnt_idx_o),
    .lat_i        (rd_lat),
    .comp_done_o  (comp_done)
  );

  sls_bus_arbiter #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) arb_i (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (go),
    .run_i        (run_q),
    .cfg_done_i   (cfg_done),
    .comp_done_i  (comp_done),
    .burst_done_i (burst_done_i),
    .nxt_len_i    (rd_len),
    .nxt_idx_o    (nxt_idx),
    .gnt_valid_o  (gnt_valid_o),
    .gnt_dir_o    (gnt_dir_o),
    .gnt_idx_o    (gnt_idx_o),
    .gnt_vec_o    (gnt_vec_o),
    .gnt_len_o    (gnt_len_o),
    .load_rel_o   (load_rel),
    .last_rel_o   (last_rel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      done_q    <= 1'b0;
      elapsed_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        run_q     <= 1'b1;
        elapsed_q <= '0;
      end else if (run_q) begin
        elapsed_q <= elapsed_q + 1'b1;
        if (last_rel) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o    = done_q;
  assign elapsed_o = elapsed_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R9

  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !gnt_valid_o); // R10

  AST_ELAPSED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_i) |=> $stable(elapsed_q)); // R9
endmodule

// File: tb/shared_bus_sequencer_tb_top.sv
module shared_bus_sequencer_tb_top;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int NS = 5;

  function automatic logic [10:0] ev(input logic d, input int i, input int e);
    logic [1:0] ii;
    logic [7:0] ee;
    ii = i[1:0];
    ee = e[7:0];
    return {d, ii, ee};
  endfunction

  // Stimulus: config time, per-unit lengths and latencies.
  // Expected: grant sequence {dir(1=result), unit, start edge} and elapsed.
  localparam logic [7:0] TR_T [NS] = '{8'd2, 8'd1, 8'd10, 8'd3, 8'd0};
  localparam logic [7:0] LEN_T [NS][N] = '{
    '{8'd3, 8'd3, 8'd3, 8'd3}, '{8'd2, 8'd2, 8'd2, 8'd2}, '{8'd2, 8'd2, 8'd2, 8'd2},
    '{8'd4, 8'd1, 8'd2, 8'd3}, '{8'd1, 8'd1, 8'd1, 8'd1}};
  localparam logic [7:0] LAT_T [NS][N] = '{
    '{8'd5, 8'd5, 8'd5, 8'd5}, '{8'd20, 8'd20, 8'd20, 8'd20}, '{8'd0, 8'd0, 8'd0, 8'd0},
    '{8'd2, 8'd7, 8'd0, 8'd1}, '{8'd0, 8'd0, 8'd0, 8'd0}};
  localparam logic [10:0] EV_T [NS][2*N] = '{
    '{ev(0,0,3), ev(0,1,6), ev(0,2,9), ev(1,0,12), ev(1,1,15), ev(1,2,18), ev(0,3,21), ev(1,3,30)},
    '{ev(0,0,2), ev(0,1,4), ev(0,2,6), ev(0,3,8), ev(1,0,25), ev(1,1,27), ev(1,2,29), ev(1,3,31)},
    '{ev(0,0,11), ev(1,0,14), ev(0,1,21), ev(1,1,24), ev(0,2,31), ev(1,2,34), ev(0,3,41), ev(1,3,44)},
    '{ev(0,0,4), ev(0,1,8), ev(0,2,10), ev(1,0,12), ev(0,3,16), ev(1,1,19), ev(1,2,20), ev(1,3,22)},
    '{ev(0,0,2), ev(0,1,3), ev(1,0,4), ev(1,1,5), ev(0,2,6), ev(0,3,7), ev(1,2,8), ev(1,3,9)}};
  localparam int ELAP_T [NS] = '{33, 33, 46, 25, 10};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_unit = '0;
  logic [1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic start = 1'b0;
  logic burst_done = 1'b0;
  logic [N-1:0] cfg_start, gnt_vec;
  logic gnt_valid, gnt_dir, done;
  logic [1:0] gnt_idx;
  logic [DW-1:0] gnt_len;
  logic [CW-1:0] elapsed;

  shared_bus_sequencer #(.N_UNITS(N), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_unit_i(wr_unit), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .start_i(start), .burst_done_i(burst_done),
    .cfg_start_o(cfg_start), .gnt_valid_o(gnt_valid), .gnt_vec_o(gnt_vec),
    .gnt_idx_o(gnt_idx), .gnt_dir_o(gnt_dir), .gnt_len_o(gnt_len),
    .done_o(done), .elapsed_o(elapsed));

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int ec = 0;
  int base = 0;
  int got_cnt = 0;
  int got_dir [16];
  int got_idx [16];
  int got_edge [16];
  int cfg_edge [N];
  int done_cnt = 0;
  int done_ec = 0;
  int done_el = 0;
  int cur_len [N] = '{1, 1, 1, 1};

  always @(posedge clk) ec <= ec + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Bus model and monitor: holds each grant for its programmed length.
  initial begin
    bit prev_v = 1'b0;
    bit prev_bd = 1'b0;
    int held = 0;
    forever begin
      @(negedge clk);
      if (gnt_valid && (!prev_v || prev_bd)) begin
        if (got_cnt < 16) begin
          got_dir[got_cnt]  = int'(gnt_dir);
          got_idx[got_cnt]  = int'(gnt_idx);
          got_edge[got_cnt] = ec;
        end
        got_cnt++;
        held = 0;
        chk("R1 R4 grant length", int'(gnt_len), cur_len[gnt_idx]);
        chk("R4 grant vector one-hot", int'(gnt_vec), 1 << gnt_idx);
      end
      if (gnt_valid) held++;
      burst_done = gnt_valid && (held >= cur_len[gnt_idx]);
      prev_v  = gnt_valid;
      prev_bd = burst_done;
      for (int k = 0; k < N; k++) if (cfg_start[k]) cfg_edge[k] = ec;
      if (done) begin
        done_cnt++;
        done_ec = ec;
        done_el = int'(elapsed);
      end
    end
  end

  task automatic wr(input int unit, input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_unit = unit[1:0]; wr_sel = sel[1:0]; wr_data = data[DW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_scn(input int s, input bit extra_start);
    int tr_eff;
    wr(0, 2, int'(TR_T[s]));                      // R1 field code 2
    for (int k = 0; k < N; k++) begin
      wr(k, 0, int'(LEN_T[s][k]));                // R1 field code 0
      wr(k, 1, int'(LAT_T[s][k]));                // R1 field code 1
      cur_len[k] = int'(LEN_T[s][k]);
    end
    for (int k = 0; k < N; k++) cfg_edge[k] = -1;
    got_cnt = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; base = ec + 1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (5) @(negedge clk);
      start = 1'b1;                               // R10: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 600 && done_cnt == 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    tr_eff = (TR_T[s] == 0) ? 1 : int'(TR_T[s]);
    for (int k = 0; k < N; k++)
      chk("R2 configure pulse edge", cfg_edge[k] - base, k * tr_eff);
    chk("R3 R6 grant count", got_cnt, 2 * N);
    for (int j = 0; j < 2 * N; j++) begin
      // R3 R5 R6 R7 R8: unit, direction and start edge of every grant
      chk(extra_start ? "R10 grant unit" : "R6 grant unit", got_idx[j], int'(EV_T[s][j][9:8]));
      chk(extra_start ? "R10 grant dir" : "R7 grant dir", got_dir[j], int'(EV_T[s][j][10]));
      chk(extra_start ? "R10 grant edge" : "R8 grant edge", got_edge[j] - base, int'(EV_T[s][j][7:0]));
    end
    chk("R9 done pulse width", done_cnt, 1);
    chk("R9 done edge", done_ec - base, ELAP_T[s]);
    chk("R9 elapsed count", done_el, ELAP_T[s]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", ec, 20000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset grant", int'(gnt_valid), 0);
    chk("R11 reset vector", int'(gnt_vec), 0);
    chk("R11 reset cfg pulse", int'(cfg_start), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset elapsed", int'(elapsed), 0);
    for (int s = 0; s < NS; s++) run_scn(s, 1'b0);
    run_scn(3, 1'b1);                             // R10 restart ignored
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule